// File: doc/BRIEF.md
# Three-bit per-pin boundary-scan register

This block is the boundary-scan data register for a row of user I/O pins. Each pin has one three-bit cell. One bit samples what arrives at the pin from outside. One bit samples the output enable that the core logic drives. One bit samples the output data that the core logic drives. All cells are chained into a single serial path. Test data enters at `scan_in`, which the test controller feeds from its serial data input. It leaves at `scan_out`, which drives the serial data output.

Every cell has a capture stage and a separate update stage.

- **Capture stage.** It is shifted or parallel-loaded on each `scan_clock` strobe. `scan_shift` chooses between the two.
- **Update stage.** On a `scan_update` strobe it copies the capture stage's output-data and output-enable bits in parallel. It holds that value while the chain is shifting.
- **Pin mux.** `scan_mode` comes from the instruction decode. It chooses what drives each pin: the update stage in test mode, or the core in normal operation.

All controls are sampled on rising edges of `clk`, the test clock. `scan_clock` and `scan_update` are therefore one-cycle enables, not clocks of their own. The state machine and instruction register that produce these controls sit outside this block.

Top module: `io_bscan_chain`

## Requirements
- R1: While `rst_n` is low, and after it is released, every capture and update bit is 0. So `scan_out` is 0, and with `scan_mode`=1 every `pin_out` and `pin_oe` bit is 0.
- R2: With `scan_mode`=0, `pin_out` equals `core_out` and `pin_oe` equals `core_oe` in the same cycle, whatever the scan registers hold.
- R3: With `scan_mode`=1, `pin_out[k]` and `pin_oe[k]` show the update-stage output-data and output-enable bits of cell k. They do not follow `core_out` or `core_oe`.
- R4: A rising edge with `scan_clock`=1 and `scan_shift`=0 loads three capture bits in parallel in every cell k: `pin_in[k]`, `core_oe[k]` and `core_out[k]`.
- R5: A rising edge with `scan_clock`=1 and `scan_shift`=1 moves every capture bit one position toward `scan_out`. Chain position p (0 nearest `scan_in`) holds these bits of cell k:
  - p = 3k: input bit
  - p = 3k+1: output-enable bit
  - p = 3k+2: output-data bit

  `scan_in` enters position 0, and `scan_out` shows position 3·NUM_PINS−1.
- R6: Without a `scan_update` strobe, the update stage holds its value. In test mode the pins therefore do not change while data shifts through the chain.
- R7: A rising edge with `scan_update`=1 copies every cell's capture output-enable and output-data bits into its update stage. The copy uses the values held before that edge.
- R8: On a rising edge with `scan_clock`=0, the capture stage keeps its value, and `scan_out` stays the same.
- R9: The chain is 3·NUM_PINS bits long. A bit presented at `scan_in` first appears at `scan_out` after exactly 3·NUM_PINS shift strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into chain position 0 |
| scan_shift | input | 1 | 1: a strobe shifts; 0: a strobe captures |
| scan_clock | input | 1 | One-cycle strobe that moves or loads the capture stage |
| scan_update | input | 1 | One-cycle strobe that loads the update stage |
| scan_mode | input | 1 | 1: pins are driven by the update stage; 0: pins are driven by the core |
| core_out | input | NUM_PINS | Output data from the core, per pin |
| core_oe | input | NUM_PINS | Output enable from the core, per pin |
| pin_in | input | NUM_PINS | Value arriving at each pin from outside |
| pin_out | output | NUM_PINS | Output data toward each pin driver |
| pin_oe | output | NUM_PINS | Output enable toward each pin driver |
| scan_out | output | 1 | Serial data from the last chain position |

## Verification
The assertions check the following on every cycle:
- the pass-through of core signals in normal mode;
- that pins stay steady in test mode while no update strobe arrives;
- that the capture stage holds when no scan strobe arrives;
- that a capture strobe puts the last cell's core output data on `scan_out`;
- the reset state.

Only the bench's scenarios show the rest. These are the full bit order within and across cells, the exact length of the chain, and that an update lands the serially loaded pattern on the right pins. Each of these needs a whole shift sequence compared against a computed vector.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int BITS_PER_CELL = 3;

    typedef struct packed {
        logic cap_in;
        logic cap_oe;
        logic cap_out;
        logic upd_oe;
        logic upd_out;
    } bsc_cell_t;

endpackage

// File: rtl/bsc_pin_mux.sv
module bsc_pin_mux (
    input  logic mode,
    input  logic core_out,
    input  logic core_oe,
    input  logic upd_out,
    input  logic upd_oe,
    output logic pin_out,
    output logic pin_oe
);

    always_comb begin
        if (mode) begin
            pin_out = upd_out;
            pin_oe  = upd_oe;
        end else begin
            pin_out = core_out;
            pin_oe  = core_oe;
        end
    end

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic si,
    input  logic shift,
    input  logic strobe,
    input  logic update,
    input  logic mode,
    input  logic pin_in,
    input  logic core_out,
    input  logic core_oe,
    output logic so,
    output logic pin_out,
    output logic pin_oe
);

    bsc_cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            if (shift) begin
                // scan-input side first: input, enable, data
                st_d.cap_in  = si;
                st_d.cap_oe  = st_q.cap_in;
                st_d.cap_out = st_q.cap_oe;
            end else begin
                st_d.cap_in  = pin_in;
                st_d.cap_oe  = core_oe;
                st_d.cap_out = core_out;
            end
        end
        if (update) begin
            st_d.upd_oe  = st_q.cap_oe;
            st_d.upd_out = st_q.cap_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign so = st_q.cap_out;

    bsc_pin_mux u_mux (
        .mode     (mode),
        .core_out (core_out),
        .core_oe  (core_oe),
        .upd_out  (st_q.upd_out),
        .upd_oe   (st_q.upd_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/io_bscan_chain.sv
module io_bscan_chain #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_in,
    input  logic                scan_shift,
    input  logic                scan_clock,
    input  logic                scan_update,
    input  logic                scan_mode,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                scan_out
);

    logic [NUM_PINS:0] link;

    assign link[0] = scan_in;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
        bsc_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .si       (link[k]),
            .shift    (scan_shift),
            .strobe   (scan_clock),
            .update   (scan_update),
            .mode     (scan_mode),
            .pin_in   (pin_in[k]),
            .core_out (core_out[k]),
            .core_oe  (core_oe[k]),
            .so       (link[k+1]),
            .pin_out  (pin_out[k]),
            .pin_oe   (pin_oe[k])
        );
    end

    assign scan_out = link[NUM_PINS];

endmodule

// File: rtl/io_bscan_chain_chk.sv
module io_bscan_chain_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_shift,
    input logic                scan_clock,
    input logic                scan_update,
    input logic                scan_mode,
    input logic [NUM_PINS-1:0] core_out,
    input logic [NUM_PINS-1:0] core_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                scan_out
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (scan_out == 1'b0));

    // R2
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode |-> (pin_out == core_out && pin_oe == core_oe));

    // R6
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode && !scan_update) |=>
            (!scan_mode || ($stable(pin_out) && $stable(pin_oe))));

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_clock |=> $stable(scan_out));

    // R4
    capture_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_clock && !scan_shift) |=> (scan_out == $past(core_out[NUM_PINS-1])));

endmodule

bind io_bscan_chain io_bscan_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_shift  (scan_shift),
    .scan_clock  (scan_clock),
    .scan_update (scan_update),
    .scan_mode   (scan_mode),
    .core_out    (core_out),
    .core_oe     (core_oe),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .scan_out    (scan_out)
);

// File: tb/sim_io_bscan_chain.sv
module sim_io_bscan_chain;

    localparam int NP  = 8;
    localparam int LEN = 3 * NP;
    localparam int NV  = 4;
    // {pin_in, core_oe, core_out, word shifted in}
    localparam logic [3*NP+LEN-1:0] VEC [NV] = '{
        {8'hA5, 8'h0F, 8'h3C, 24'hF0F0F0},
        {8'hFF, 8'h00, 8'hFF, 24'h000001},
        {8'h00, 8'hFF, 8'h81, 24'hAAAAAA},
        {8'h5A, 8'hC3, 8'h00, 24'h800000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_in = 1'b0, scan_shift = 1'b0, scan_clock = 1'b0;
    logic scan_update = 1'b0, scan_mode = 1'b0;
    logic [NP-1:0] core_out = '0, core_oe = '0, pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic scan_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    io_bscan_chain #(.NUM_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_shift(scan_shift),
        .scan_clock(scan_clock), .scan_update(scan_update), .scan_mode(scan_mode),
        .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .scan_out(scan_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle with the given strobes; returns just after the edge
    task automatic cyc(input logic s, input logic c, input logic u, input logic d);
        scan_shift = s; scan_clock = c; scan_update = u; scan_in = d;
        @(posedge clk); #1;
        scan_clock = 1'b0; scan_update = 1'b0;
    endtask

    function automatic logic [LEN-1:0] cap_word(input logic [NP-1:0] pi,
                                                input logic [NP-1:0] oe,
                                                input logic [NP-1:0] od);
        logic [LEN-1:0] w;
        for (int k = 0; k < NP; k++) begin
            w[3*k]   = pi[k];
            w[3*k+1] = oe[k];
            w[3*k+2] = od[k];
        end
        return w;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] got, w, expc;
        logic [NP-1:0] hold_o, hold_e;
        int steps;

        #1;
        scan_mode = 1'b1;
        #1;
        // R1: state while reset is held
        chk("R1 scan_out in reset", 64'(scan_out), 64'd0);
        chk("R1 pins in reset", {32'(pin_out), 32'(pin_oe)}, 64'd0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", {31'd0, scan_out, 16'(pin_out), 16'(pin_oe)}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            {pin_in, core_oe, core_out, w} = VEC[i];
            scan_mode = 1'b0;
            #1;
            chk("R2 core passes in normal mode", {32'(pin_out), 32'(pin_oe)},
                {32'(core_out), 32'(core_oe)});
            cyc(1'b0, 1'b1, 1'b0, 1'b0);
            expc = cap_word(pin_in, core_oe, core_out);
            scan_mode = 1'b1;
            #1;
            hold_o = pin_out; hold_e = pin_oe;
            core_out = ~core_out; core_oe = ~core_oe;
            for (int j = 0; j < LEN; j++) begin
                got[LEN-1-j] = scan_out;
                cyc(1'b1, 1'b1, 1'b0, w[LEN-1-j]);
            end
            chk("R4 R5 captured word shifted out", 64'(got), 64'(expc));
            chk("R6 pins held during shift", {32'(pin_out), 32'(pin_oe)},
                {32'(hold_o), 32'(hold_e)});
            cyc(1'b0, 1'b0, 1'b1, 1'b0);
            for (int k = 0; k < NP; k++) begin
                hold_o[k] = w[3*k+2];
                hold_e[k] = w[3*k+1];
            end
            chk("R7 R3 update drives pins", {32'(pin_out), 32'(pin_oe)},
                {32'(hold_o), 32'(hold_e)});
        end

        // R8: no strobe keeps the capture stage
        core_out = '0; core_oe = '0; pin_in = '0;
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        repeat (5) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        got = '0;
        for (int j = 0; j < LEN; j++) begin
            got[LEN-1-j] = scan_out;
            cyc(1'b1, 1'b1, 1'b0, 1'b0);
        end
        chk("R8 held chain contents", 64'(got), 64'h7);

        // R9: chain length
        steps = 0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        steps = 1;
        while (scan_out !== 1'b1 && steps < 4 * LEN) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0);
            steps++;
        end
        chk("R9 strobes to reach scan_out", 64'(steps), 64'(LEN));

        // R3: core changes do not reach pins in test mode
        hold_o = pin_out; hold_e = pin_oe;
        core_out = 8'hFF; core_oe = 8'hFF;
        #1;
        chk("R3 core ignored in test mode", {32'(pin_out), 32'(pin_oe)},
            {32'(hold_o), 32'(hold_e)});

        // R7: update and shift on the same edge use the pre-edge capture value
        core_out = 8'h80; core_oe = 8'h00;
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R7 simultaneous update uses old capture", {32'(pin_out[NP-1]), 32'(pin_oe[NP-1])},
            {32'd1, 32'd0});

        // R1: reset mid-run clears the chain
        #1 rst_n = 1'b0;
        #1;
        chk("R1 reset clears", {31'd0, scan_out, 16'(pin_out), 16'(pin_oe)}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule